// File: doc/BRIEF.md
# Byte Multiply and Divide Unit

This block is the sequential arithmetic engine that serves the accumulator-and-B-register multiply and divide operations of a small 8-bit processor core. A one-cycle start pulse hands it the two operand bytes and an operation select. It then iterates one bit per clock and raises a one-cycle done pulse with two result bytes and two flag bits. Instruction decode and the writeback of the results into the register file belong to the surrounding core.

For a multiply, the low byte of the unsigned product goes out on the accumulator result and the high byte on the B result. The overflow flag reports that the product does not fit in one byte. For a divide, the accumulator operand is the dividend and the B operand is the divisor. The quotient goes out on the accumulator result and the remainder on the B result. A zero divisor is flagged through overflow, and in that case no iteration is run. The carry flag is always cleared.

The unit runs a shift-add loop for multiply and a restoring shift-subtract loop for divide. Both loops share one pair of working registers. The result registers hold their values between done pulses.

Top module: `bmd_unit`

## Requirements
- R1: With `op_div` = 0 (multiply), at done `acc_out` is bits 7:0 and `breg_out` is bits 15:8 of the unsigned product `acc_in * breg_in`.
- R2: For a multiply, `ov_out` is 1 at done exactly when the product is greater than 8'hFF, and 0 otherwise.
- R3: With `op_div` = 1 (divide) and a non-zero `breg_in`, at done `acc_out` is the quotient `acc_in / breg_in` and `breg_out` is the remainder `acc_in % breg_in`, with `ov_out` = 0.
- R4: A divide with `breg_in` = 0 sets `ov_out` = 1, returns `acc_out` = `acc_in` and `breg_out` = 0, and raises done one clock after the clock edge that accepts the start.
- R5: For a multiply or a non-zero divide, done rises W+1 clocks after the edge that accepts the start, where W = 8 is the operand width.
- R6: `cy_out` is 0 after every multiply and every divide.
- R7: `done` is high for exactly one clock per accepted operation.
- R8: A start pulse that arrives while an operation is in progress is ignored. The running operation's results and done timing are unchanged.
- R9: `acc_out`, `breg_out` and `ov_out` keep their values from one done pulse until the next, whatever the inputs do in between.
- R10: After the synchronous reset, `done`, `acc_out`, `breg_out`, `ov_out` and `cy_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin an operation |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| acc_in | input | 8 | Accumulator operand (multiplicand or dividend) |
| breg_in | input | 8 | B operand (multiplier or divisor) |
| done | output | 1 | One-cycle pulse: results valid |
| acc_out | output | 8 | Low product byte or quotient |
| breg_out | output | 8 | High product byte or remainder |
| cy_out | output | 1 | Carry flag, always 0 |
| ov_out | output | 1 | Product exceeds one byte, or the divisor is zero |

## Verification
Counting from the edge that accepts the start, results for a multiply or a non-zero divide are due W+1 = 9 edges later. A zero-divisor divide delivers its results one edge later. The bench drives every input on falling edges and counts falling edges until done appears. This count must be exactly 10, or 2 for the zero-divisor case, and the values are checked at that same falling edge. The following falling edge must show done low and the outputs unchanged, even though the inputs have been scrambled in between. Some runs inject a start pulse in the middle of the loop to confirm that the latency and the results stay those of the first request.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } bmd_state_e;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } bmd_op_e;
endpackage

// File: rtl/bmd_mul_step.sv
// One shift-add multiply iteration: conditionally add the multiplicand
// to the high half, then shift the {high, low} pair right by one bit.
module bmd_mul_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] hi_n,
  output logic [W-1:0] lo_n
);
  logic [W:0] sum;

  always_comb begin
    sum  = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);
    hi_n = sum[W:1];
    lo_n = {sum[0], lo[W-1:1]};
  end
endmodule

// File: rtl/bmd_div_step.sv
// One restoring divide iteration: shift the next dividend bit into the
// partial remainder and keep the trial difference when it does not borrow.
module bmd_div_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] rem_n,
  output logic [W-1:0] quo_n
);
  logic [W:0] part;
  logic [W:0] diff;

  always_comb begin
    part = {rem, quo[W-1]};
    diff = part - {1'b0, dvsr};
    if (!diff[W]) begin
      rem_n = diff[W-1:0];
      quo_n = {quo[W-2:0], 1'b1};
    end else begin
      rem_n = part[W-1:0];
      quo_n = {quo[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/bmd_ctrl.sv
// Sequencer: idle, W iteration cycles, one finish cycle.
module bmd_ctrl
  import bmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic skip_run,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  bmd_state_e st_q;
  logic [CW-1:0] cnt_q;

  assign busy   = (st_q != ST_IDLE);
  assign load   = (st_q == ST_IDLE) && start;
  assign step   = (st_q == ST_RUN);
  assign finish = (st_q == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) st_q <= skip_run ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            st_q  <= ST_FIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5: the loop ends after the last count
  p_loop_end_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && cnt_q == LAST) |=> (st_q == ST_FIN));

  // R7: a finish cycle is followed by idle
  p_finish_once_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FIN) |=> (st_q == ST_IDLE));

  // R5: the counter is only non-zero inside the loop
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN) |-> (cnt_q == '0));
endmodule

// File: rtl/bmd_unit.sv
module bmd_unit
  import bmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] breg_in,
  output logic         done,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] breg_out,
  output logic         cy_out,
  output logic         ov_out
);
  logic load, step, finish, busy;
  logic skip_run;

  bmd_op_e     op_q;
  logic        zdiv_q;
  logic [W-1:0] opnd_q;
  logic [W-1:0] hi_q, lo_q;
  logic [W-1:0] m_hi, m_lo, d_hi, d_lo;

  assign skip_run = op_div && (breg_in == '0);

  bmd_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .skip_run (skip_run),
    .load     (load),
    .step     (step),
    .finish   (finish),
    .busy     (busy)
  );

  bmd_mul_step #(.W(W)) u_mul (
    .hi    (hi_q),
    .lo    (lo_q),
    .mcand (opnd_q),
    .hi_n  (m_hi),
    .lo_n  (m_lo)
  );

  bmd_div_step #(.W(W)) u_div (
    .rem   (hi_q),
    .quo   (lo_q),
    .dvsr  (opnd_q),
    .rem_n (d_hi),
    .quo_n (d_lo)
  );

  // Shared working registers: high half / remainder, low half / quotient
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_MUL;
      zdiv_q <= 1'b0;
      opnd_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (load) begin
      op_q   <= op_div ? OP_DIV : OP_MUL;
      zdiv_q <= skip_run;
      opnd_q <= breg_in;
      hi_q   <= '0;
      lo_q   <= acc_in;
    end else if (step) begin
      if (op_q == OP_DIV) begin
        hi_q <= d_hi;
        lo_q <= d_lo;
      end else begin
        hi_q <= m_hi;
        lo_q <= m_lo;
      end
    end
  end

  // Registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      acc_out  <= '0;
      breg_out <= '0;
      ov_out   <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        acc_out  <= lo_q;
        breg_out <= hi_q;
        ov_out   <= (op_q == OP_DIV) ? zdiv_q : (hi_q != '0);
      end
    end
  end

  assign cy_out = 1'b0;

  // R3: a valid remainder is below the divisor
  p_rem_below_r3: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_DIV && !ov_out) |-> (breg_out < opnd_q));

  // R4: zero divisor finishes without iterating
  p_zero_div_fast_r4: assert property (@(posedge clk) disable iff (rst)
    (load && skip_run) |=> ##1 done);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: a start while busy leaves the captured operation alone
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(opnd_q) && $stable(op_q)));

  // R9: results change only together with done
  p_hold_out_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(acc_out) && $stable(breg_out) && $stable(ov_out)));
endmodule

// File: tb/bmd_unit_tb.sv
module bmd_unit_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         op_div = 1'b0;
  logic [W-1:0] acc_in = '0;
  logic [W-1:0] breg_in = '0;
  logic         done;
  logic [W-1:0] acc_out, breg_out;
  logic         cy_out, ov_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bmd_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div),
    .acc_in(acc_in), .breg_in(breg_in), .done(done),
    .acc_out(acc_out), .breg_out(breg_out), .cy_out(cy_out), .ov_out(ov_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return (2*W)'(a) * (2*W)'(b);
  endfunction

  task automatic run_op(input bit dv, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit intrude);
    int lat;
    bit got;
    logic [W-1:0] ea, eb;
    logic eov;
    int elat;
    logic [2*W-1:0] p;
    logic [W-1:0] ha, hb;
    logic hov;
    @(negedge clk);
    start = 1'b1; op_div = dv; acc_in = a; breg_in = b;
    lat = 0; got = 1'b0;
    while (!got && lat < 40) begin
      @(negedge clk);
      lat++;
      if (done) got = 1'b1;
      else if (intrude && lat == 3) begin
        start = 1'b1; op_div = ~dv; acc_in = $urandom; breg_in = $urandom;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (!dv) begin
      p = ref_mul(a, b);
      ea = p[W-1:0]; eb = p[2*W-1:W]; eov = (p > 16'h00FF); elat = W + 2;
    end else if (b == 0) begin
      ea = a; eb = '0; eov = 1'b1; elat = 2;
    end else begin
      ea = a / b; eb = a % b; eov = 1'b0; elat = W + 2;
    end
    if (dv && b == 0) chk(lat == elat, "R4 latency", lat, elat);
    else if (intrude) chk(lat == elat, "R8 latency with busy start", lat, elat);
    else chk(lat == elat, "R5 latency", lat, elat);
    if (!dv) begin
      chk(acc_out == ea, "R1 low product byte", acc_out, ea);
      chk(breg_out == eb, "R1 high product byte", breg_out, eb);
      chk(ov_out == eov, "R2 multiply overflow", ov_out, eov);
    end else if (b == 0) begin
      chk(acc_out == ea, "R4 acc kept", acc_out, ea);
      chk(breg_out == eb, "R4 breg zero", breg_out, eb);
      chk(ov_out == eov, "R4 overflow set", ov_out, eov);
    end else begin
      chk(acc_out == ea, "R3 quotient", acc_out, ea);
      chk(breg_out == eb, "R3 remainder", breg_out, eb);
      chk(ov_out == eov, "R3 overflow clear", ov_out, eov);
    end
    chk(cy_out == 1'b0, "R6 carry clear", cy_out, 0);
    ha = acc_out; hb = breg_out; hov = ov_out;
    acc_in = $urandom; breg_in = $urandom; op_div = $urandom;
    @(negedge clk);
    chk(done == 1'b0, "R7 single done", done, 0);
    repeat (2) @(negedge clk);
    chk(acc_out == ha && breg_out == hb && ov_out == hov, "R9 hold",
        {ov_out, breg_out, acc_out}, {hov, hb, ha});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && acc_out == 0 && breg_out == 0 && ov_out == 0 && cy_out == 0,
        "R10 reset state", {done, ov_out, cy_out, breg_out, acc_out}, 0);
    // directed corners
    run_op(1'b0, 8'hFF, 8'hFF, 1'b0);
    run_op(1'b0, 8'h10, 8'h10, 1'b0);
    run_op(1'b0, 8'h0F, 8'h11, 1'b0);
    run_op(1'b0, 8'h00, 8'hA5, 1'b0);
    run_op(1'b1, 8'hFF, 8'h01, 1'b0);
    run_op(1'b1, 8'h07, 8'h08, 1'b0);
    run_op(1'b1, 8'hFF, 8'hFF, 1'b0);
    run_op(1'b1, 8'h64, 8'h00, 1'b0);
    run_op(1'b1, 8'h00, 8'h00, 1'b0);
    run_op(1'b0, 8'hC3, 8'h5A, 1'b1);
    run_op(1'b1, 8'hC3, 8'h05, 1'b1);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom;
      if (($urandom % 8) == 0) b = '0;
      run_op(1'($urandom), a, b, (($urandom % 4) == 0));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule